// File: doc/BRIEF.md
# Configurable Parallel I/O Port Multiplexer

This block controls a port of up to 32 pins. Software sets it up through a small register bus. There are five per-pin control registers: pin assignment, function option, direction, open-drain and output data. Each bit of each register affects only the pin at the same bit position. For every pin, the block chooses what drives the pad. The source is the general-purpose data latch, dedicated peripheral function 1, or dedicated peripheral function 2. From that choice it produces the pad output value and the output-enable.

Each pad input is passed to the peripheral input that owns the pin. A peripheral input that does not own the pin receives a fixed per-pin default level, so an unused function always sees a known value. Register reads are combinational. Register writes take effect at the next clock edge. The asynchronous active-low reset is released synchronously inside the block.

Top module: `pio_port_mux`

## Requirements
- R1: After reset every control register reads 0, every pad output-enable is 0, and reading the data register returns the pad input.
- R2: A write with `bus_we`=1 stores `bus_wdata` at the next rising clock edge into the register at `bus_addr`. The addresses are: assignment 0, option 1, direction 2, open-drain 3, data 4. Registers 0 to 3 read back what was written. Addresses 5 to 7 read as 0.
- R3: A pin with assignment 0 and direction 1 that is not open-drain drives its data-register bit with output-enable 1.
- R4: A pin with assignment 1 takes its output value from `f1_out` when its option bit is 0, and from `f2_out` when its option bit is 1. With direction 1 its output-enable is 1.
- R5: A pin with assignment 1 and direction 0 is bidirectional. Its output-enable follows the selected function's `f1_oe` or `f2_oe`.
- R6: A pin with assignment 0 and direction 0 never enables its driver.
- R7: An open-drain pin that would drive never outputs 1. When it drives a 0 value, output-enable is 1 and `pad_out` is 0. When it drives a 1 value, output-enable is 0.
- R8: Reading the data register returns `pad_in` for pins with direction 0 and the data-register bit for pins with direction 1.
- R9: `f1_in` carries `pad_in` only when the pin has assignment 1, option 0 and direction 0. `f2_in` carries `pad_in` only when the pin has assignment 1, option 1 and direction 0.
- R10: In every other case a peripheral input carries the pin's default from parameter `DFLT_LVL`. The default is 32'hFFFF_0000: pins 0 to 15 are request-type inputs and see 0, and pins 16 to 31 are done-type signals and see 1.
- R11: A data-register write to a pin with direction 0 is still stored, and the pin drives the stored value once its direction becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Register write data |
| bus_rdata | output | NPINS | Register read data (combinational) |
| pad_in | input | NPINS | Value seen on each pad |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Pad driver enable |
| f1_out | input | NPINS | Dedicated function 1 output value |
| f1_oe | input | NPINS | Dedicated function 1 drive request for bidirectional pins |
| f1_in | output | NPINS | Input delivered to dedicated function 1 |
| f2_out | input | NPINS | Dedicated function 2 output value |
| f2_oe | input | NPINS | Dedicated function 2 drive request for bidirectional pins |
| f2_in | output | NPINS | Input delivered to dedicated function 2 |

## Verification
The routing is tested in stages. First, all pins are general-purpose outputs with alternating data, which isolates the latch path. Next, all pins are dedicated, with an option mask of 0F0F_0F0F. This shows whether function 1 or function 2 drives each pin, and which function receives the pad. Then the direction register is cleared while the peripheral enables toggle, which separates a bidirectional pin from a fixed output. After that, an open-drain mask is laid over random data, which shows whether a 1 is ever driven actively. A long phase with random configuration and pad values mixes all modes across neighbouring bits, and catches any bit that borrows a neighbour's control.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_ASSIGN = 3'd0,
    RA_OPTION = 3'd1,
    RA_DIR    = 3'd2,
    RA_ODRAIN = 3'd3,
    RA_DATA   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]      bus_wdata,
  input  logic [NPINS-1:0]      pad_in,
  output logic [NPINS-1:0]      bus_rdata,
  output logic [NPINS-1:0]      asg_q,
  output logic [NPINS-1:0]      opt_q,
  output logic [NPINS-1:0]      dir_q,
  output logic [NPINS-1:0]      od_q,
  output logic [NPINS-1:0]      dat_q
);
  logic wr_asg, wr_opt, wr_dir, wr_od, wr_dat;

  always_comb begin
    wr_asg = bus_we && (bus_addr == RA_ASSIGN);
    wr_opt = bus_we && (bus_addr == RA_OPTION);
    wr_dir = bus_we && (bus_addr == RA_DIR);
    wr_od  = bus_we && (bus_addr == RA_ODRAIN);
    wr_dat = bus_we && (bus_addr == RA_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asg_q <= '0;
      opt_q <= '0;
      dir_q <= '0;
      od_q  <= '0;
      dat_q <= '0;
    end else begin
      if (wr_asg) asg_q <= bus_wdata;
      if (wr_opt) opt_q <= bus_wdata;
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_od)  od_q  <= bus_wdata;
      if (wr_dat) dat_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      RA_ASSIGN: bus_rdata = asg_q;
      RA_OPTION: bus_rdata = opt_q;
      RA_DIR:    bus_rdata = dir_q;
      RA_ODRAIN: bus_rdata = od_q;
      RA_DATA:   bus_rdata = (dir_q & dat_q) | (~dir_q & pad_in);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_pin_slice.sv
module pio_pin_slice #(
  parameter logic DFLT = 1'b0
) (
  input  logic asg,
  input  logic opt,
  input  logic dir,
  input  logic od,
  input  logic dat,
  input  logic f1_out,
  input  logic f1_oe,
  input  logic f2_out,
  input  logic f2_oe,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic f1_in,
  output logic f2_in
);
  logic src_val;
  logic src_oe;
  logic drive;
  logic own1, own2;

  always_comb begin
    src_val = asg ? (opt ? f2_out : f1_out) : dat;
    src_oe  = asg & (opt ? f2_oe : f1_oe);
    drive   = dir | (~dir & src_oe);
    if (od) begin
      pad_out = 1'b0;
      pad_oe  = drive & ~src_val;
    end else begin
      pad_out = src_val;
      pad_oe  = drive;
    end
    own1  = asg & ~opt & ~dir;
    own2  = asg &  opt & ~dir;
    f1_in = own1 ? pad_in : DFLT;
    f2_in = own2 ? pad_in : DFLT;
  end
endmodule

// File: rtl/pio_port_mux.sv
module pio_port_mux
  import pio_pkg::*;
#(
  parameter int unsigned     NPINS    = 32,
  parameter logic [NPINS-1:0] DFLT_LVL = {{(NPINS/2){1'b1}}, {(NPINS-NPINS/2){1'b0}}}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]      bus_wdata,
  output logic [NPINS-1:0]      bus_rdata,
  input  logic [NPINS-1:0]      pad_in,
  output logic [NPINS-1:0]      pad_out,
  output logic [NPINS-1:0]      pad_oe,
  input  logic [NPINS-1:0]      f1_out,
  input  logic [NPINS-1:0]      f1_oe,
  output logic [NPINS-1:0]      f1_in,
  input  logic [NPINS-1:0]      f2_out,
  input  logic [NPINS-1:0]      f2_oe,
  output logic [NPINS-1:0]      f2_in
);
  logic             rst_s;
  logic [NPINS-1:0] asg_q, opt_q, dir_q, od_q, dat_q;

  pio_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s)
  );

  pio_regfile #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .bus_rdata (bus_rdata),
    .asg_q     (asg_q),
    .opt_q     (opt_q),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .dat_q     (dat_q)
  );

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    pio_pin_slice #(.DFLT(DFLT_LVL[gi])) u_slice (
      .asg     (asg_q[gi]),
      .opt     (opt_q[gi]),
      .dir     (dir_q[gi]),
      .od      (od_q[gi]),
      .dat     (dat_q[gi]),
      .f1_out  (f1_out[gi]),
      .f1_oe   (f1_oe[gi]),
      .f2_out  (f2_out[gi]),
      .f2_oe   (f2_oe[gi]),
      .pad_in  (pad_in[gi]),
      .pad_out (pad_out[gi]),
      .pad_oe  (pad_oe[gi]),
      .f1_in   (f1_in[gi]),
      .f2_in   (f2_in[gi])
    );
  end
endmodule

// File: rtl/pio_port_mux_chk.sv
module pio_port_mux_chk #(
  parameter int unsigned      NPINS    = 32,
  parameter logic [NPINS-1:0] DFLT_LVL = '0
) (
  input logic             clk,
  input logic             rst_s,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] asg,
  input logic [NPINS-1:0] opt,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] od,
  input logic [NPINS-1:0] dat,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] f1_in
);
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_we && bus_addr == 3'd0) |=> (asg == $past(bus_wdata))); // R2

  AST_GP_OUT_DATA: assert property (@(posedge clk) disable iff (!rst_s)
    ((dir & ~od & ~asg & (pad_out ^ dat)) == '0)); // R3

  AST_GP_IN_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    ((~asg & ~dir & pad_oe) == '0)); // R6

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_s)
    ((od & pad_oe & pad_out) == '0)); // R7

  AST_READ_LATCH: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr == 3'd4) |-> ((dir & (bus_rdata ^ dat)) == '0)); // R8

  AST_DESEL_DFLT: assert property (@(posedge clk) disable iff (!rst_s)
    ((asg & opt & (f1_in ^ DFLT_LVL)) == '0)); // R10
endmodule

bind pio_port_mux pio_port_mux_chk #(.NPINS(NPINS), .DFLT_LVL(DFLT_LVL)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .asg       (asg_q),
  .opt       (opt_q),
  .dir       (dir_q),
  .od        (od_q),
  .dat       (dat_q),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .f1_in     (f1_in)
);

// File: tb/pio_port_mux_tb_top.sv
module pio_port_mux_tb_top;
  localparam int N = 32;
  localparam logic [N-1:0] DFLT = 32'hFFFF_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [2:0]   bus_addr = 3'd0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;
  logic [N-1:0] f1_out = '0, f1_oe = '0, f1_in;
  logic [N-1:0] f2_out = '0, f2_oe = '0, f2_in;

  int checks = 0;
  int fails = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  logic [N-1:0] m_asg = '0, m_opt = '0, m_dir = '0, m_od = '0, m_dat = '0;

  always #10 clk = ~clk;

  pio_port_mux #(.NPINS(N), .DFLT_LVL(DFLT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .f1_out(f1_out), .f1_oe(f1_oe),
    .f1_in(f1_in), .f2_out(f2_out), .f2_oe(f2_oe), .f2_in(f2_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: register state follows bus writes
  always @(posedge clk) begin
    if (live && bus_we) begin
      case (bus_addr)
        3'd0: m_asg <= bus_wdata;
        3'd1: m_opt <= bus_wdata;
        3'd2: m_dir <= bus_wdata;
        3'd3: m_od  <= bus_wdata;
        3'd4: m_dat <= bus_wdata;
        default: ;
      endcase
    end
  end

  function automatic string pin_tag(input int i);
    if (m_od[i]) return "R7";
    if (m_asg[i]) return m_dir[i] ? "R4" : "R5";
    return m_dir[i] ? "R3" : "R6";
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #5;
    if (live && !done) begin
      logic [N-1:0] e_out, e_oe, e_f1, e_f2, e_rd;
      string t_out, t_oe;
      t_out = "R3";
      t_oe = "R6";
      for (int i = 0; i < N; i++) begin
        bit src, drv;
        src = m_asg[i] ? (m_opt[i] ? f2_out[i] : f1_out[i]) : m_dat[i];
        drv = m_dir[i] ? 1'b1 : (m_asg[i] && (m_opt[i] ? f2_oe[i] : f1_oe[i]));
        e_out[i] = m_od[i] ? 1'b0 : src;
        e_oe[i]  = m_od[i] ? (drv && !src) : drv;
        e_f1[i]  = (m_asg[i] && !m_opt[i] && !m_dir[i]) ? pad_in[i] : DFLT[i];
        e_f2[i]  = (m_asg[i] &&  m_opt[i] && !m_dir[i]) ? pad_in[i] : DFLT[i];
        if (pad_out[i] !== e_out[i]) t_out = pin_tag(i);
        if (pad_oe[i] !== e_oe[i]) t_oe = pin_tag(i);
      end
      case (bus_addr)
        3'd0: e_rd = m_asg;
        3'd1: e_rd = m_opt;
        3'd2: e_rd = m_dir;
        3'd3: e_rd = m_od;
        3'd4: e_rd = (m_dir & m_dat) | (~m_dir & pad_in);
        default: e_rd = '0;
      endcase
      chk(pad_out === e_out, {t_out, " pad_out"}, pad_out, e_out);
      chk(pad_oe === e_oe, {t_oe, " pad_oe"}, pad_oe, e_oe);
      chk(f1_in === e_f1, "R9 R10 f1_in", f1_in, e_f1);
      chk(f2_in === e_f2, "R9 R10 f2_in", f2_in, e_f2);
      chk(bus_rdata === e_rd, (bus_addr == 3'd4) ? "R8 rdata" : "R2 rdata", bus_rdata, e_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bus_addr = 3'(k % 8);
      pad_in = $urandom; f1_out = $urandom; f2_out = $urandom;
      f1_oe = $urandom; f2_oe = $urandom;
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state through the ports
    pad_in = 32'hA5C3_0F96;
    for (int a = 0; a < 4; a++) begin
      bus_addr = 3'(a);
      #1 chk(bus_rdata == '0, "R1 reg clear", bus_rdata, '0);
    end
    bus_addr = 3'd4;
    #1 chk(bus_rdata == pad_in, "R1 data reads pad", bus_rdata, pad_in);
    chk(pad_oe == '0, "R1 no drive", pad_oe, '0);
    chk(f1_in == DFLT, "R10 default after reset", f1_in, DFLT);
    live = 1'b1;

    // R2: write and read back each register, unmapped addresses
    wr(3'd0, 32'h1234_5678); wr(3'd1, 32'h9ABC_DEF0);
    wr(3'd2, 32'h0F0F_F0F0); wr(3'd3, 32'h3333_CCCC); wr(3'd4, 32'h5555_AAAA);
    idle(16);
    for (int a = 0; a < 4; a++) wr(3'(a), '0);

    // R3: general-purpose outputs
    wr(3'd2, '1);
    wr(3'd4, 32'hAAAA_5555); idle(4);
    wr(3'd4, 32'h5555_AAAA); idle(4);

    // R4: dedicated outputs, function choice by option mask
    wr(3'd1, 32'h0F0F_0F0F);
    wr(3'd0, '1); idle(20);

    // R5 R9 R10: bidirectional dedicated pins
    wr(3'd2, '0); idle(30);
    wr(3'd1, 32'hF0F0_F0F0); idle(20);
    wr(3'd0, 32'h00FF_FF00); idle(20);

    // R7: open-drain over mixed modes
    wr(3'd3, 32'hFF00_FF00); wr(3'd2, 32'h0F0F_0F0F); idle(30);

    // R11: data stored while input, driven after direction flip
    for (int a = 0; a < 4; a++) wr(3'(a), '0);
    wr(3'd4, 32'hC3C3_3C3C);
    @(negedge clk); bus_addr = 3'd4; pad_in = 32'h0;
    #1 chk(bus_rdata == 32'h0, "R11 input still reads pad", bus_rdata, 32'h0);
    wr(3'd2, '1);
    @(negedge clk); bus_addr = 3'd4;
    #1 chk(pad_out == 32'hC3C3_3C3C && pad_oe == '1, "R11 latched data driven",
           pad_out, 32'hC3C3_3C3C);
    chk(bus_rdata == 32'hC3C3_3C3C, "R11 read latch", bus_rdata, 32'hC3C3_3C3C);

    // mixed random configuration
    for (int r = 0; r < 40; r++) begin
      wr(3'($urandom_range(0, 4)), $urandom);
      idle(4);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule